// File: doc/BRIEF.md
# Microcontroller Integer Execute Unit

This block is the integer execute stage of a small 32-bit command-processor microcontroller. Each cycle it can accept one instruction word together with two source operands, already read from the register file by the surrounding harness. It also takes the current value of the destination register, which the bitfield-insert operation merges into. One clock later it presents the 32-bit result, the destination register index and a write enable.

The instruction set centres on compact bit manipulation. It covers shifts and a left rotate, an 8-bit multiply, unsigned minimum and maximum, and a compare that yields a code word. It also has bit-clear, a highest-set-bit search, single-bit set and clear with the bit index taken from either the instruction or an operand, bitfield extract and insert, and a shifted 16-bit move-immediate.

The format is chosen by bits 27-31 of the word. There is a register-register form, a short-immediate form for five of the operations, a grouped form whose sub-operation sits in bits 12-15, and the move-immediate form. An encoding that matches none of these raises an illegal flag and suppresses the write.

Top module: `mcu_exec_unit`

## Requirements
- R1: Outputs are registered with one cycle of latency. `dst_idx_o` carries instruction bits 16-20. `wr_en_o` is high only for a valid, legal instruction. All outputs are zero during reset and after a cycle with `valid_i` low.
- R2: When bits 27-31 are 00000 the word is register-register form. The second operand is `src2_i`, and bits 0-4 select the operation: 10010 shift left, 10011 logical shift right, 10100 arithmetic shift right, 10101 rotate left, 01001 bit-clear, 01010 min, 01011 max, 01100 mul8, 01101 compare, 11001 msb, 10110 dynamic set-bit.
- R3: Shift and rotate amounts are the low 5 bits of the second operand. The logical right shift fills with zeros, the arithmetic right shift fills with the sign bit, and the rotate moves bits leaving the top back in at bit 0.
- R4: Bit-clear returns src1 AND NOT operand2. Min and max compare as unsigned. mul8 returns the 16-bit product of the low bytes, zero-extended.
- R5: Compare (unsigned) returns 0x2b when the operands are equal, 0x00 when src1 is greater, and 0x1e when src1 is less.
- R6: msb returns the index of the highest set bit of `src2_i`, or 0 when `src2_i` is zero. `src1_i` has no effect.
- R7: Dynamic set-bit writes bit 0 of the second operand into src1 at the position given by bits 1-5 of the second operand. All other bits pass through unchanged.
- R8: When bits 27-31 equal one of the register-form codes 01001, 01010, 01011, 01100 or 01101, the same operation runs on the zero-extended immediate in bits 0-15, and `src2_i` is ignored.
- R9: When bits 27-31 are 10010, bits 12-15 pick the sub-operation and the zero-extended bits 0-11 form the second operand: 0010 shift left, 0011 logical right, 0100 arithmetic right, 0101 rotate, 0110 set/clear bit, 0111 extract, 1000 insert. `src2_i` is ignored.
- R10: Grouped set/clear bit uses bits 1-5 as the bit index and bit 0 as the new value (1 sets, 0 clears).
- R11: Extract uses lo = bits 0-4 and hi = bits 5-9, and returns (src1 >> lo) masked to w bits, where w = ((hi - lo) mod 32) + 1.
- R12: Insert takes the low w bits of src1 (w as in R11), shifts them left by lo, and ORs them into `dst_cur_i`.
- R13: When bits 27-31 are 01110, the result is the 16-bit immediate in bits 0-15 shifted left by bits 21-25, truncated to 32 bits.
- R14: Any other encoding, including an unlisted register-form code or sub-operation, gives `illegal_o` high, `wr_en_o` low and a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction present this cycle |
| instr_i | input | 32 | Instruction word |
| src1_i | input | 32 | First source operand |
| src2_i | input | 32 | Second source operand (register forms) |
| dst_cur_i | input | 32 | Current destination register value |
| result_o | output | 32 | Result to write back |
| dst_idx_o | output | 5 | Destination register index |
| wr_en_o | output | 1 | Write-back enable |
| illegal_o | output | 1 | Undecodable instruction seen |

## Verification
The bench targets the cases where a near-miss implementation still gives a plausible word. The arithmetic shift uses a negative operand, because a logical fill there drops the sign. Rotate and shift amounts carry high bits above bit 4, so a design that does not mask the amount returns zero. Min and max take an all-ones operand, which a signed compare would order wrongly. The compare runs all three orderings, so swapped code words show up. The bitfield cases include a full 32-bit extract, where a naive mask overflows to zero, and a wrapped hi-below-lo field. An insert into the top nibble with a non-zero destination shows whether the design merges with `dst_cur_i` or overwrites it. Immediate forms drive a junk `src2_i`, so a design that muxes the wrong operand is exposed. Unknown sub-operations and formats must neither write nor leak a result.

// File: rtl/exu_pkg.sv
package exu_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned INSN_W = 32;

  typedef enum logic [3:0] {
    OP_NONE, OP_SHL, OP_LSR, OP_ASR, OP_ROT, OP_BIC, OP_MIN, OP_MAX,
    OP_MUL8, OP_CMP, OP_MSB, OP_SETBIT, OP_BFX, OP_BFI, OP_MOVI
  } op_e;

  // format selector, insn[31:27]
  localparam logic [4:0] FMT_REG  = 5'b00000;
  localparam logic [4:0] FMT_GRP  = 5'b10010;
  localparam logic [4:0] FMT_MOVI = 5'b01110;

  // register-form codes, insn[4:0]; bic..cmp reused in insn[31:27]
  localparam logic [4:0] C_SHL  = 5'b10010;
  localparam logic [4:0] C_LSR  = 5'b10011;
  localparam logic [4:0] C_ASR  = 5'b10100;
  localparam logic [4:0] C_ROT  = 5'b10101;
  localparam logic [4:0] C_BIC  = 5'b01001;
  localparam logic [4:0] C_MIN  = 5'b01010;
  localparam logic [4:0] C_MAX  = 5'b01011;
  localparam logic [4:0] C_MUL8 = 5'b01100;
  localparam logic [4:0] C_CMP  = 5'b01101;
  localparam logic [4:0] C_MSB  = 5'b11001;
  localparam logic [4:0] C_SETB = 5'b10110;

  // grouped sub-ops, insn[15:12]
  localparam logic [3:0] S_SHL  = 4'h2;
  localparam logic [3:0] S_LSR  = 4'h3;
  localparam logic [3:0] S_ASR  = 4'h4;
  localparam logic [3:0] S_ROT  = 4'h5;
  localparam logic [3:0] S_SETB = 4'h6;
  localparam logic [3:0] S_BFX  = 4'h7;
  localparam logic [3:0] S_BFI  = 4'h8;

  localparam logic [7:0] CMP_EQ = 8'h2b;
  localparam logic [7:0] CMP_GT = 8'h00;
  localparam logic [7:0] CMP_LT = 8'h1e;
endpackage

// File: rtl/exu_decode.sv
module exu_decode
  import exu_pkg::*;
#(
  parameter int unsigned DATA_W = XLEN
) (
  input  logic [4:0]        fmt_i,
  input  logic [15:0]       imm_i,
  input  logic [DATA_W-1:0] src2_i,
  output op_e               op_o,
  output logic [DATA_W-1:0] opb_o,
  output logic              ill_o
);
  always_comb begin
    op_o  = OP_NONE;
    opb_o = src2_i;
    case (fmt_i)
      FMT_REG: begin
        case (imm_i[4:0])
          C_SHL:   op_o = OP_SHL;
          C_LSR:   op_o = OP_LSR;
          C_ASR:   op_o = OP_ASR;
          C_ROT:   op_o = OP_ROT;
          C_BIC:   op_o = OP_BIC;
          C_MIN:   op_o = OP_MIN;
          C_MAX:   op_o = OP_MAX;
          C_MUL8:  op_o = OP_MUL8;
          C_CMP:   op_o = OP_CMP;
          C_MSB:   op_o = OP_MSB;
          C_SETB:  op_o = OP_SETBIT;
          default: op_o = OP_NONE;
        endcase
      end
      FMT_GRP: begin
        opb_o = DATA_W'(imm_i[11:0]);
        case (imm_i[15:12])
          S_SHL:   op_o = OP_SHL;
          S_LSR:   op_o = OP_LSR;
          S_ASR:   op_o = OP_ASR;
          S_ROT:   op_o = OP_ROT;
          S_SETB:  op_o = OP_SETBIT;  // same bit layout as dynamic form
          S_BFX:   op_o = OP_BFX;
          S_BFI:   op_o = OP_BFI;
          default: op_o = OP_NONE;
        endcase
      end
      FMT_MOVI: begin
        op_o  = OP_MOVI;
        opb_o = DATA_W'(imm_i);
      end
      C_BIC:  begin op_o = OP_BIC;  opb_o = DATA_W'(imm_i); end
      C_MIN:  begin op_o = OP_MIN;  opb_o = DATA_W'(imm_i); end
      C_MAX:  begin op_o = OP_MAX;  opb_o = DATA_W'(imm_i); end
      C_MUL8: begin op_o = OP_MUL8; opb_o = DATA_W'(imm_i); end
      C_CMP:  begin op_o = OP_CMP;  opb_o = DATA_W'(imm_i); end
      default: op_o = OP_NONE;
    endcase
  end

  assign ill_o = (op_o == OP_NONE);
endmodule

// File: rtl/exu_shift.sv
module exu_shift
  import exu_pkg::*;
#(
  parameter int unsigned DATA_W = XLEN,
  localparam int unsigned SH_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  op_e               op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [SH_W-1:0]   amt_i,
  output logic [DATA_W-1:0] res_o
);
  logic [2*DATA_W-1:0] rot_wide;

  assign rot_wide = {a_i, a_i} << amt_i;

  always_comb begin
    case (op_i)
      OP_SHL:  res_o = a_i << amt_i;
      OP_LSR:  res_o = a_i >> amt_i;
      OP_ASR:  res_o = DATA_W'($signed(a_i) >>> amt_i);
      OP_ROT:  res_o = rot_wide[2*DATA_W-1:DATA_W];
      default: res_o = '0;
    endcase
  end

  assert_rot_keeps_ones_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_ROT) |-> ($countones(res_o) == $countones(a_i)));

  assert_asr_sign_fill_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_ASR) |-> (res_o[DATA_W-1] == a_i[DATA_W-1]));
endmodule

// File: rtl/exu_arith.sv
module exu_arith
  import exu_pkg::*;
#(
  parameter int unsigned DATA_W = XLEN,
  parameter int unsigned MUL_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  op_e               op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int unsigned PROD_W = 2 * MUL_W;

  logic [PROD_W-1:0] prod;
  logic [7:0]        cmp_code;

  assign prod = a_i[MUL_W-1:0] * b_i[MUL_W-1:0];

  always_comb begin
    if (a_i == b_i)     cmp_code = CMP_EQ;
    else if (a_i > b_i) cmp_code = CMP_GT;
    else                cmp_code = CMP_LT;
  end

  always_comb begin
    case (op_i)
      OP_BIC:  res_o = a_i & ~b_i;
      OP_MIN:  res_o = (a_i < b_i) ? a_i : b_i;
      OP_MAX:  res_o = (a_i > b_i) ? a_i : b_i;
      OP_MUL8: res_o = DATA_W'(prod);
      OP_CMP:  res_o = DATA_W'(cmp_code);
      default: res_o = '0;
    endcase
  end

  assert_cmp_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CMP) |-> (res_o == DATA_W'(CMP_EQ) || res_o == DATA_W'(CMP_GT) ||
                          res_o == DATA_W'(CMP_LT)));

  assert_min_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_MIN) |-> (res_o <= a_i && res_o <= b_i));

  assert_max_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_MAX) |-> (res_o >= a_i && res_o >= b_i));
endmodule

// File: rtl/exu_bitops.sv
module exu_bitops
  import exu_pkg::*;
#(
  parameter int unsigned DATA_W = XLEN,
  localparam int unsigned SH_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  op_e               op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] res_o
);
  localparam logic [SH_W-1:0] TOP_BIT = SH_W'(DATA_W - 1);

  logic [SH_W-1:0]   bit_idx;
  logic              bit_val;
  logic [SH_W-1:0]   fld_lo;
  logic [SH_W-1:0]   fld_hi;
  logic [SH_W-1:0]   fld_span;
  logic [DATA_W-1:0] fld_mask;
  logic [SH_W-1:0]   msb_idx;

  assign bit_idx  = b_i[SH_W:1];
  assign bit_val  = b_i[0];
  assign fld_lo   = b_i[SH_W-1:0];
  assign fld_hi   = b_i[2*SH_W-1:SH_W];
  assign fld_span = fld_hi - fld_lo;              // wraps mod DATA_W
  assign fld_mask = {DATA_W{1'b1}} >> (TOP_BIT - fld_span);

  always_comb begin
    msb_idx = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (b_i[i]) msb_idx = SH_W'(i);
    end
  end

  always_comb begin
    case (op_i)
      OP_SETBIT: begin
        res_o          = a_i;
        res_o[bit_idx] = bit_val;
      end
      OP_BFX:  res_o = (a_i >> fld_lo) & fld_mask;
      OP_BFI:  res_o = d_i | ((a_i & fld_mask) << fld_lo);
      OP_MSB:  res_o = DATA_W'(msb_idx);
      default: res_o = '0;
    endcase
  end

  assert_setbit_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SETBIT) |-> ($countones(res_o ^ a_i) <= 1));

  assert_msb_hits_one_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_MSB && b_i != '0) |-> (b_i[res_o[SH_W-1:0]] && (b_i >> res_o[SH_W-1:0]) == 1));

  assert_bfi_keeps_dst_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_BFI) |-> ((res_o & d_i) == d_i));
endmodule

// File: rtl/mcu_exec_unit.sv
module mcu_exec_unit
  import exu_pkg::*;
#(
  parameter int unsigned DATA_W = XLEN,
  parameter int unsigned IDX_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [INSN_W-1:0] instr_i,
  input  logic [DATA_W-1:0] src1_i,
  input  logic [DATA_W-1:0] src2_i,
  input  logic [DATA_W-1:0] dst_cur_i,
  output logic [DATA_W-1:0] result_o,
  output logic [IDX_W-1:0]  dst_idx_o,
  output logic              wr_en_o,
  output logic              illegal_o
);
  localparam int unsigned SH_W   = $clog2(DATA_W);
  localparam int unsigned DST_LO = 16;
  localparam int unsigned MSH_LO = 21;

  op_e               op;
  logic [DATA_W-1:0] opb;
  logic              ill;
  logic [DATA_W-1:0] sh_res, ar_res, bit_res, mov_res;
  logic [DATA_W-1:0] res_d;
  logic              unused_rsvd;

  assign unused_rsvd = instr_i[26];

  exu_decode #(.DATA_W(DATA_W)) u_dec (
    .fmt_i (instr_i[31:27]),
    .imm_i (instr_i[15:0]),
    .src2_i(src2_i),
    .op_o  (op),
    .opb_o (opb),
    .ill_o (ill)
  );

  exu_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .op_i  (op),
    .a_i   (src1_i),
    .amt_i (opb[SH_W-1:0]),
    .res_o (sh_res)
  );

  exu_arith #(.DATA_W(DATA_W)) u_arith (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .op_i  (op),
    .a_i   (src1_i),
    .b_i   (opb),
    .res_o (ar_res)
  );

  exu_bitops #(.DATA_W(DATA_W)) u_bits (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .op_i  (op),
    .a_i   (src1_i),
    .b_i   (opb),
    .d_i   (dst_cur_i),
    .res_o (bit_res)
  );

  assign mov_res = opb << instr_i[MSH_LO +: SH_W];

  always_comb begin
    case (op)
      OP_SHL, OP_LSR, OP_ASR, OP_ROT:          res_d = sh_res;
      OP_BIC, OP_MIN, OP_MAX, OP_MUL8, OP_CMP: res_d = ar_res;
      OP_MSB, OP_SETBIT, OP_BFX, OP_BFI:       res_d = bit_res;
      OP_MOVI:                                 res_d = mov_res;
      default:                                 res_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o  <= '0;
      dst_idx_o <= '0;
      wr_en_o   <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      result_o  <= (valid_i && !ill) ? res_d : '0;
      dst_idx_o <= valid_i ? instr_i[DST_LO +: IDX_W] : '0;
      wr_en_o   <= valid_i && !ill;
      illegal_o <= valid_i && ill;
    end
  end

  assert_write_needs_valid_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(valid_i));

  assert_dst_from_insn_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (dst_idx_o == $past(instr_i[DST_LO +: IDX_W])));

  assert_illegal_no_write_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!wr_en_o && result_o == '0));

  assert_movi_low_zero_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op == OP_MOVI) |=> (wr_en_o &&
      (result_o & ((DATA_W'(1) << $past(instr_i[MSH_LO +: SH_W])) - 1)) == '0));
endmodule

// File: tb/test_mcu_exec_unit.sv
`timescale 1ns/1ps
module test_mcu_exec_unit;
  typedef struct packed {
    logic [31:0] ins;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] d;
    logic [31:0] e;
    logic        ill;
    logic [3:0]  req;
  } vec_t;

  function automatic logic [31:0] rr(input logic [4:0] op, input logic [4:0] dst);
    return {5'b00000, 1'b0, 5'd1, dst, 11'd0, op};
  endfunction
  function automatic logic [31:0] im(input logic [4:0] fmt, input logic [4:0] dst,
                                     input logic [15:0] imm);
    return {fmt, 1'b0, 5'd2, dst, imm};
  endfunction
  function automatic logic [31:0] gp(input logic [3:0] sub, input logic [4:0] dst,
                                     input logic [11:0] imm);
    return {5'b10010, 1'b0, 5'd3, dst, sub, imm};
  endfunction
  function automatic logic [31:0] mv(input logic [4:0] sh, input logic [4:0] dst,
                                     input logic [15:0] imm);
    return {5'b01110, 1'b0, sh, dst, imm};
  endfunction

  localparam logic [31:0] JNK = 32'hDEAD_BEEF;
  localparam logic [31:0] DJK = 32'hA5A5_A5A5;
  localparam int NV = 38;

  localparam vec_t TBL [NV] = '{
    // R2 R3 register shifts, amount high bits ignored
    '{rr(5'b10010, 5'd1),  32'h0000_00F1, 32'h0000_0024, DJK, 32'h0000_0F10, 1'b0, 4'd3},
    '{rr(5'b10011, 5'd2),  32'h8000_0010, 32'h0000_0004, DJK, 32'h0800_0001, 1'b0, 4'd3},
    '{rr(5'b10100, 5'd3),  32'h8000_0010, 32'h0000_0004, DJK, 32'hF800_0001, 1'b0, 4'd3},
    '{rr(5'b10101, 5'd4),  32'h8000_0001, 32'hFFFF_FFE1, DJK, 32'h0000_0003, 1'b0, 4'd3},
    // R2 R4 bic min max mul8
    '{rr(5'b01001, 5'd5),  32'hFFFF_00FF, 32'h0F0F_0F0F, DJK, 32'hF0F0_00F0, 1'b0, 4'd4},
    '{rr(5'b01010, 5'd6),  32'h0000_0005, 32'hFFFF_FFFF, DJK, 32'h0000_0005, 1'b0, 4'd4},
    '{rr(5'b01011, 5'd7),  32'h0000_0005, 32'hFFFF_FFFF, DJK, 32'hFFFF_FFFF, 1'b0, 4'd4},
    '{rr(5'b01100, 5'd8),  32'h1234_56FF, 32'h00AB_CDFF, DJK, 32'h0000_FE01, 1'b0, 4'd4},
    // R5 compare orderings
    '{rr(5'b01101, 5'd9),  32'h0000_0007, 32'h0000_0007, DJK, 32'h0000_002B, 1'b0, 4'd5},
    '{rr(5'b01101, 5'd10), 32'h0000_0009, 32'h0000_0007, DJK, 32'h0000_0000, 1'b0, 4'd5},
    '{rr(5'b01101, 5'd11), 32'h0000_0007, 32'h0000_0009, DJK, 32'h0000_001E, 1'b0, 4'd5},
    // R6 msb, src1 ignored
    '{rr(5'b11001, 5'd12), 32'hFFFF_FFFF, 32'h0001_2000, DJK, 32'h0000_0010, 1'b0, 4'd6},
    '{rr(5'b11001, 5'd13), 32'hFFFF_FFFF, 32'h0000_0000, DJK, 32'h0000_0000, 1'b0, 4'd6},
    // R7 dynamic set-bit
    '{rr(5'b10110, 5'd14), 32'h0000_0000, 32'h0000_003F, DJK, 32'h8000_0000, 1'b0, 4'd7},
    '{rr(5'b10110, 5'd15), 32'hFFFF_FFFF, 32'h0000_0008, DJK, 32'hFFFF_FFEF, 1'b0, 4'd7},
    // R8 short-immediate forms, junk src2
    '{im(5'b01001, 5'd16, 16'h00FF), 32'hFFFF_FFFF, JNK, DJK, 32'hFFFF_FF00, 1'b0, 4'd8},
    '{im(5'b01010, 5'd17, 16'h1234), 32'h0001_0000, JNK, DJK, 32'h0000_1234, 1'b0, 4'd8},
    '{im(5'b01011, 5'd18, 16'h8000), 32'h0000_0003, JNK, DJK, 32'h0000_8000, 1'b0, 4'd8},
    '{im(5'b01100, 5'd19, 16'h0120), 32'h0000_0010, JNK, DJK, 32'h0000_0200, 1'b0, 4'd8},
    '{im(5'b01101, 5'd20, 16'h1234), 32'h0000_1234, JNK, DJK, 32'h0000_002B, 1'b0, 4'd8},
    // R9 grouped shifts
    '{gp(4'h2, 5'd21, 12'h021), 32'h0000_0003, JNK, DJK, 32'h0000_0006, 1'b0, 4'd9},
    '{gp(4'h3, 5'd22, 12'h004), 32'hF000_0000, JNK, DJK, 32'h0F00_0000, 1'b0, 4'd9},
    '{gp(4'h4, 5'd23, 12'h01F), 32'h8000_0000, JNK, DJK, 32'hFFFF_FFFF, 1'b0, 4'd9},
    '{gp(4'h5, 5'd24, 12'h008), 32'h1234_5678, JNK, DJK, 32'h3456_7812, 1'b0, 4'd9},
    // R10 grouped set/clear
    '{gp(4'h6, 5'd25, 12'h007), 32'h0000_0000, JNK, DJK, 32'h0000_0008, 1'b0, 4'd10},
    '{gp(4'h6, 5'd26, 12'h03E), 32'hFFFF_FFFF, JNK, DJK, 32'h7FFF_FFFF, 1'b0, 4'd10},
    // R11 extract: normal, full width, wrapped hi<lo
    '{gp(4'h7, 5'd27, 12'h164), 32'h1234_5678, JNK, DJK, 32'h0000_0067, 1'b0, 4'd11},
    '{gp(4'h7, 5'd28, 12'h3E0), 32'hCAFE_F00D, JNK, DJK, 32'hCAFE_F00D, 1'b0, 4'd11},
    '{gp(4'h7, 5'd29, 12'h068), 32'hFFFF_FFFF, JNK, DJK, 32'h00FF_FFFF, 1'b0, 4'd11},
    // R12 insert merges into dst
    '{gp(4'h8, 5'd30, 12'h1E8), 32'h0000_12AB, JNK, 32'h0000_0001, 32'h0000_AB01, 1'b0, 4'd12},
    '{gp(4'h8, 5'd31, 12'h3FC), 32'h0000_00F5, JNK, 32'h0000_00FF, 32'h5000_00FF, 1'b0, 4'd12},
    // R13 move-immediate
    '{mv(5'd16, 5'd1, 16'hBEEF), 32'h0, JNK, DJK, 32'hBEEF_0000, 1'b0, 4'd13},
    '{mv(5'd0,  5'd2, 16'h1234), 32'h0, JNK, DJK, 32'h0000_1234, 1'b0, 4'd13},
    '{mv(5'd20, 5'd3, 16'hFFFF), 32'h0, JNK, DJK, 32'hFFF0_0000, 1'b0, 4'd13},
    // R14 illegal encodings
    '{rr(5'b00001, 5'd4),         32'h1, 32'h1, DJK, 32'h0, 1'b1, 4'd14},
    '{gp(4'h0, 5'd5, 12'h001),    32'h1, JNK, DJK, 32'h0, 1'b1, 4'd14},
    '{im(5'b11111, 5'd6, 16'h1),  32'h1, JNK, DJK, 32'h0, 1'b1, 4'd14},
    '{gp(4'hF, 5'd7, 12'h001),    32'h1, JNK, DJK, 32'h0, 1'b1, 4'd14}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] instr = '0, src1 = '0, src2 = '0, dcur = '0;
  logic [31:0] result;
  logic [4:0]  dst_idx;
  logic        wr_en, illegal;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  mcu_exec_unit i_mcu_exec_unit (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .valid_i  (valid),
    .instr_i  (instr),
    .src1_i   (src1),
    .src2_i   (src2),
    .dst_cur_i(dcur),
    .result_o (result),
    .dst_idx_o(dst_idx),
    .wr_en_o  (wr_en),
    .illegal_o(illegal)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic v, input logic [31:0] ins, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] d);
    @(negedge clk);
    valid = v; instr = ins; src1 = a; src2 = b; dcur = d;
    @(negedge clk);   // one register stage: result visible here
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state with a legal instruction pending
    valid = 1'b1; instr = TBL[0].ins; src1 = TBL[0].a; src2 = TBL[0].b;
    repeat (3) @(negedge clk);
    chk("R1", "reset result", result, 32'h0);
    chk("R1", "reset dst", {27'd0, dst_idx}, 32'h0);
    chk("R1", "reset wr_en", {31'd0, wr_en}, 32'h0);
    chk("R1", "reset illegal", {31'd0, illegal}, 32'h0);
    valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", TBL[i].req);
      issue(1'b1, TBL[i].ins, TBL[i].a, TBL[i].b, TBL[i].d);
      chk(tag, $sformatf("vec %0d result", i), result, TBL[i].e);
      chk(tag, $sformatf("vec %0d wr_en", i), {31'd0, wr_en}, {31'd0, !TBL[i].ill});
      chk(tag, $sformatf("vec %0d illegal", i), {31'd0, illegal}, {31'd0, TBL[i].ill});
      if (!TBL[i].ill)
        chk("R1", $sformatf("vec %0d dst", i), {27'd0, dst_idx}, {27'd0, TBL[i].ins[20:16]});
    end

    // R1 valid low: legal instruction must not write
    issue(1'b0, TBL[4].ins, TBL[4].a, TBL[4].b, DJK);
    chk("R1", "idle wr_en", {31'd0, wr_en}, 32'h0);
    chk("R1", "idle result", result, 32'h0);

    // R14 illegal with valid low raises nothing
    issue(1'b0, TBL[34].ins, 32'h1, 32'h1, DJK);
    chk("R14", "idle illegal", {31'd0, illegal}, 32'h0);

    // R7 set-bit with value equal to current bit leaves operand unchanged
    issue(1'b1, rr(5'b10110, 5'd9), 32'h0000_0100, 32'hFFFF_FF11, DJK);
    chk("R7", "setbit no-op", result, 32'h0000_0100);

    // R11 single-bit field at top
    issue(1'b1, gp(4'h7, 5'd10, {2'b00, 5'd31, 5'd31}), 32'h8000_0000, JNK, DJK);
    chk("R11", "top bit extract", result, 32'h0000_0001);

    // R12 insert does not clear dst bits under the field
    issue(1'b1, gp(4'h8, 5'd11, {2'b00, 5'd7, 5'd0}), 32'h0000_0000, JNK, 32'h0000_00FF);
    chk("R12", "insert zero keeps dst", result, 32'h0000_00FF);

    // R3 rotate by zero
    issue(1'b1, gp(4'h5, 5'd12, 12'h020), 32'h8765_4321, JNK, DJK);
    chk("R3", "rotate by 0", result, 32'h8765_4321);

    // R5 compare with immediate less-than
    issue(1'b1, im(5'b01101, 5'd13, 16'hFFFF), 32'h0000_0001, JNK, DJK);
    chk("R5", "cmpi lt", result, 32'h0000_001E);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule